// File: doc/BRIEF.md
# Double-Buffered Bulk IN Endpoint Buffer

This block is the transmit buffer of one bulk IN endpoint in a USB device controller. Firmware pushes bytes through a single 8-bit write-only port. Internal counters choose every storage address. Two banks of equal size take turns: one is filled from the CPU side, and the other is held for the serial interface engine (SIE), which drains it when the host sends an IN token.

A filled bank moves to the SIE side only when the SIE side holds no committed packet. The CPU-side bank must also either be completely full or have been closed by firmware with the data-end control. Closing a partly filled bank sends a short packet. Closing an empty bank sends a zero-length packet.

The SIE side answers each IN token with one of two responses. It gives a data response when a packet is committed and transmission is enabled, and a NAK otherwise. It then reads the packet bytes in order. A host acknowledge frees the bank and raises the transmit-done interrupt flag. A missing acknowledge rewinds the read position so that the same packet is sent again.

Top module: `bulkin_pingpong`

## Requirements
- R1: A bank moves to the SIE side only when no packet is committed there and the CPU-side bank is either full (BANK_BYTES bytes) or closed by data-end. `data_present` goes to 1 on the clock after that condition first holds.
- R2: Firmware supplies no address. Byte k written after a bank was emptied is the k-th byte returned on `sie_rd_data`, counting from 0, and each `sie_rd_en` cycle advances the read position by one.
- R3: A write is ignored while the CPU-side bank holds BANK_BYTES bytes or while data-end is pending. It changes neither the stored bytes nor the packet length.
- R4: Closing a bank that holds N bytes, with 0 < N < BANK_BYTES, commits a packet of length exactly N.
- R5: Closing an empty bank commits a packet of length 0, and `data_present` still goes to 1.
- R6: On the clock after `sie_in_token`, `sie_resp_data` pulses for one cycle if a packet is committed and `cpu_tx_enable` is 1, with `sie_pkt_len` giving its length. Otherwise `sie_resp_nak` pulses for one cycle. The two are never high together.
- R7: `sie_ack` while a packet is committed clears `data_present` and sets `tx_done` and `irq` on the next clock.
- R8: `tx_done` is cleared by a `cpu_irq_clr` pulse. If an acknowledge arrives in the same cycle as the clear, the flag stays set.
- R9: `data_end_pending` is set by `cpu_data_end`, stays set while the SIE side is occupied, and clears on the clock on which the bank swap happens.
- R10: `cpu_clear` empties the CPU-side bank by resetting its byte count. The packet committed on the SIE side keeps its length and bytes.
- R11: `sie_noack` returns the read position to byte 0, so the next IN token resends the same packet from its first byte.
- R12: `cpu_rd_data` is always 0x00.
- R13: After reset, no packet is committed, both flags are 0, no response is driven and data-end is not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Byte write strobe on the data port |
| cpu_wr_data | input | DATA_W | Byte written by firmware |
| cpu_rd_data | output | DATA_W | Data port read value, always 0 |
| cpu_data_end | input | 1 | Pulse that closes the CPU-side bank |
| cpu_clear | input | 1 | Pulse that empties the CPU-side bank |
| cpu_tx_enable | input | 1 | Level: 1 lets IN tokens get data, 0 forces NAK |
| cpu_irq_clr | input | 1 | Write-1 clear of the transmit-done flag |
| data_end_pending | output | 1 | Data-end requested and not yet consumed |
| data_present | output | 1 | A packet is committed on the SIE side |
| tx_done | output | 1 | Transmit-done status flag |
| irq | output | 1 | Interrupt request to the CPU |
| sie_in_token | input | 1 | IN token received for this endpoint |
| sie_resp_data | output | 1 | One-cycle data response to a token |
| sie_resp_nak | output | 1 | One-cycle NAK response to a token |
| sie_pkt_len | output | CNT_W | Length of the committed packet |
| sie_rd_en | input | 1 | Pop one byte from the SIE-side bank |
| sie_rd_data | output | DATA_W | Byte at the current read position |
| sie_ack | input | 1 | Host acknowledged the packet |
| sie_noack | input | 1 | Transaction ended without acknowledge |

## Verification
The bench targets the swap condition from three sides, each with the SIE side still occupied:
- a full bank, where an extra write must not wrap onto byte 0;
- a closed bank, where a later write must not stretch the packet;
- a cleared bank, where the committed packet must keep its bytes.

A design that swapped early, or let the byte counter wrap, would deliver a wrong length or a corrupted first byte. Zero-length and one-byte packets check that a committed empty packet still reports as present and answers with data rather than NAK. A missing rewind on no-acknowledge would resend from mid-packet. An acknowledge arriving together with the interrupt clear checks that a new completion is never lost.

// File: rtl/bip_pkg.sv
package bip_pkg;
  // Response the SIE side gives to an IN token.
  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_DATA = 2'd1,
    RESP_NAK  = 2'd2
  } resp_e;
endpackage

// File: rtl/bip_bank_mem.sv
module bip_bank_mem #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned N_BANKS = 2,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned SEL_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_bank,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_bank,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank_q [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic              bank_we;

    assign bank_we = wr_en && (wr_bank == SEL_W'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem[wr_addr] <= wr_data;
    end

    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/bip_cpu_side.sv
module bip_cpu_side #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clear,
  input  logic             data_end_set,
  input  logic             swap,
  output logic             wr_accept,
  output logic [PTR_W-1:0] wr_addr,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             dend
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dend_q, dend_d;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign wr_accept = wr_en && !full && !dend_q;
  assign wr_addr   = cnt_q[PTR_W-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    dend_d = dend_q;
    if (swap)           cnt_d = '0;
    else if (clear)     cnt_d = '0;
    else if (wr_accept) cnt_d = cnt_q + CNT_W'(1);
    if (swap)              dend_d = 1'b0;
    else if (data_end_set) dend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dend_q <= dend_d;
    end
  end

  assign cnt  = cnt_q;
  assign dend = dend_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R9
  dend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !dend_q);
  // R3
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dend_q && !swap && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/bip_sie_side.sv
module bip_sie_side
  import bip_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  input  logic             tx_enable,
  input  logic             in_token,
  input  logic             rd_en,
  input  logic             ack,
  input  logic             noack,
  input  logic             irq_clr,
  output logic             valid,
  output logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] rd_ptr,
  output logic             resp_data,
  output logic             resp_nak,
  output logic             tx_done
);
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  resp_e            resp_q, resp_d;
  logic             done_q, done_d;
  logic             release_pkt;

  assign release_pkt = ack && valid_q;

  always_comb begin
    valid_d = valid_q;
    len_d   = len_q;
    ptr_d   = ptr_q;
    resp_d  = RESP_NONE;
    done_d  = done_q;
    if (load) begin
      valid_d = 1'b1;
      len_d   = load_len;
    end else if (release_pkt) begin
      valid_d = 1'b0;
    end
    if (ack || noack || load)                      ptr_d = '0;
    else if (rd_en && valid_q && (ptr_q < len_q))  ptr_d = ptr_q + CNT_W'(1);
    if (in_token) resp_d = (valid_q && tx_enable) ? RESP_DATA : RESP_NAK;
    if (release_pkt)  done_d = 1'b1;
    else if (irq_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      len_q   <= '0;
      ptr_q   <= '0;
      resp_q  <= RESP_NONE;
      done_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      len_q   <= len_d;
      ptr_q   <= ptr_d;
      resp_q  <= resp_d;
      done_q  <= done_d;
    end
  end

  assign valid     = valid_q;
  assign len       = len_q;
  assign rd_ptr    = ptr_q;
  assign resp_data = (resp_q == RESP_DATA);
  assign resp_nak  = (resp_q == RESP_NAK);
  assign tx_done   = done_q;

  // R6
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_data, resp_nak}));
  // R6
  token_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_token |=> (resp_data || resp_nak));
  // R7
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && valid_q) |=> (tx_done && !valid_q));
  // R11
  noack_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noack |=> (ptr_q == '0));
  // R2
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= len_q);
endmodule

// File: rtl/bulkin_pingpong.sv
module bulkin_pingpong #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_BYTES = 64,
  localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1),
  localparam int unsigned PTR_W     = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic [DATA_W-1:0] cpu_rd_data,
  input  logic              cpu_data_end,
  input  logic              cpu_clear,
  input  logic              cpu_tx_enable,
  input  logic              cpu_irq_clr,
  output logic              data_end_pending,
  output logic              data_present,
  output logic              tx_done,
  output logic              irq,
  input  logic              sie_in_token,
  output logic              sie_resp_data,
  output logic              sie_resp_nak,
  output logic [CNT_W-1:0]  sie_pkt_len,
  input  logic              sie_rd_en,
  output logic [DATA_W-1:0] sie_rd_data,
  input  logic              sie_ack,
  input  logic              sie_noack
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic             cpu_sel_q, cpu_sel_d;
  logic             swap;
  logic             wr_accept;
  logic [PTR_W-1:0] wr_addr;
  logic [CNT_W-1:0] cpu_cnt;
  logic             cpu_full;
  logic             cpu_dend;
  logic             sie_valid;
  logic [CNT_W-1:0] sie_len;
  logic [CNT_W-1:0] sie_ptr;
  logic             done;

  assign swap      = !sie_valid && (cpu_full || cpu_dend);
  assign cpu_sel_d = swap ? !cpu_sel_q : cpu_sel_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cpu_sel_q <= 1'b0;
    else        cpu_sel_q <= cpu_sel_d;
  end

  bip_cpu_side #(.DEPTH(BANK_BYTES)) u_cpu (
    .clk          (clk),
    .rst_n        (rst_q),
    .wr_en        (cpu_wr_en),
    .clear        (cpu_clear),
    .data_end_set (cpu_data_end),
    .swap         (swap),
    .wr_accept    (wr_accept),
    .wr_addr      (wr_addr),
    .cnt          (cpu_cnt),
    .full         (cpu_full),
    .dend         (cpu_dend)
  );

  bip_sie_side #(.DEPTH(BANK_BYTES)) u_sie (
    .clk       (clk),
    .rst_n     (rst_q),
    .load      (swap),
    .load_len  (cpu_cnt),
    .tx_enable (cpu_tx_enable),
    .in_token  (sie_in_token),
    .rd_en     (sie_rd_en),
    .ack       (sie_ack),
    .noack     (sie_noack),
    .irq_clr   (cpu_irq_clr),
    .valid     (sie_valid),
    .len       (sie_len),
    .rd_ptr    (sie_ptr),
    .resp_data (sie_resp_data),
    .resp_nak  (sie_resp_nak),
    .tx_done   (done)
  );

  bip_bank_mem #(.DATA_W(DATA_W), .DEPTH(BANK_BYTES), .N_BANKS(2)) u_mem (
    .clk     (clk),
    .wr_en   (wr_accept),
    .wr_bank (cpu_sel_q),
    .wr_addr (wr_addr),
    .wr_data (cpu_wr_data),
    .rd_bank (!cpu_sel_q),
    .rd_addr (sie_ptr[PTR_W-1:0]),
    .rd_data (sie_rd_data)
  );

  assign cpu_rd_data      = '0;
  assign data_end_pending = cpu_dend;
  assign data_present     = sie_valid;
  assign sie_pkt_len      = sie_len;
  assign tx_done          = done;
  assign irq              = done;

  // R1
  swap_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(data_present) |-> $past(cpu_full || cpu_dend));
  // R1
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(data_present) |-> (cpu_sel_q != $past(cpu_sel_q)));
  // R10
  sie_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sie_valid && !sie_ack) |=> $stable(sie_len));
endmodule

// File: tb/sim_bulkin_pingpong.sv
module sim_bulkin_pingpong;
  localparam int DW = 8;
  localparam int BB = 64;
  localparam int CW = $clog2(BB + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_wr_en, cpu_data_end, cpu_clear, cpu_tx_enable, cpu_irq_clr;
  logic [DW-1:0] cpu_wr_data, cpu_rd_data, sie_rd_data;
  logic          data_end_pending, data_present, tx_done, irq;
  logic          sie_in_token, sie_resp_data, sie_resp_nak, sie_rd_en, sie_ack, sie_noack;
  logic [CW-1:0] sie_pkt_len;

  int n_run = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bulkin_pingpong #(.DATA_W(DW), .BANK_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
    .cpu_data_end(cpu_data_end), .cpu_clear(cpu_clear), .cpu_tx_enable(cpu_tx_enable),
    .cpu_irq_clr(cpu_irq_clr), .data_end_pending(data_end_pending),
    .data_present(data_present), .tx_done(tx_done), .irq(irq),
    .sie_in_token(sie_in_token), .sie_resp_data(sie_resp_data), .sie_resp_nak(sie_resp_nak),
    .sie_pkt_len(sie_pkt_len), .sie_rd_en(sie_rd_en), .sie_rd_data(sie_rd_data),
    .sie_ack(sie_ack), .sie_noack(sie_noack)
  );

  // Vector: [15:8] packet length, [7:0] first data byte. Lengths below BB are closed by data-end.
  localparam logic [15:0] VEC [6] = '{16'h40_10, 16'h0A_F8, 16'h00_00,
                                      16'h01_5A, 16'h3F_C3, 16'h02_FF};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); cpu_wr_en = 1'b1; cpu_wr_data = b;
    @(negedge clk); cpu_wr_en = 1'b0;
  endtask

  task automatic close_bank();
    @(negedge clk); cpu_data_end = 1'b1;
    @(negedge clk); cpu_data_end = 1'b0;
  endtask

  task automatic fill(input int n, input logic [7:0] seed, input logic close);
    for (int i = 0; i < n; i++) wr_byte(8'(seed + i));
    if (close) close_bank();
    repeat (2) @(negedge clk);
  endtask

  task automatic token(input string req, input int exp_data, input int exp_len);
    @(negedge clk); sie_in_token = 1'b1;
    @(negedge clk); sie_in_token = 1'b0;
    chk({req, " resp_data"}, int'(sie_resp_data), exp_data);
    chk({req, " resp_nak"}, int'(sie_resp_nak), 1 - exp_data);
    if (exp_data == 1) chk({req, " pkt_len"}, int'(sie_pkt_len), exp_len);
  endtask

  task automatic drain(input string req, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(sie_rd_data), int'(8'(seed + i)));
      sie_rd_en = 1'b1;
      @(negedge clk); sie_rd_en = 1'b0;
    end
  endtask

  task automatic do_ack();
    @(negedge clk); sie_ack = 1'b1;
    @(negedge clk); sie_ack = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); cpu_irq_clr = 1'b1;
    @(negedge clk); cpu_irq_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_wr_en = 0; cpu_wr_data = 0; cpu_data_end = 0; cpu_clear = 0;
    cpu_tx_enable = 1; cpu_irq_clr = 0; sie_in_token = 0; sie_rd_en = 0;
    sie_ack = 0; sie_noack = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state, R12 read port
    chk("R13 data_present", int'(data_present), 0);
    chk("R13 tx_done", int'(tx_done), 0);
    chk("R13 irq", int'(irq), 0);
    chk("R13 data_end_pending", int'(data_end_pending), 0);
    chk("R13 resp", int'(sie_resp_data | sie_resp_nak), 0);
    chk("R12 cpu_rd_data", int'(cpu_rd_data), 0);

    // R6 NAK with nothing committed
    token("R6 empty", 0, 0);

    // Table walk: R1 R2 R4 R5 R7 R8
    foreach (VEC[k]) begin
      int         n;
      logic [7:0] s;
      n = int'(VEC[k][15:8]);
      s = VEC[k][7:0];
      fill(n, s, n < BB);
      chk("R1 data_present", int'(data_present), 1);
      chk("R9 dend cleared", int'(data_end_pending), 0);
      token(n == 0 ? "R5 zlp" : (n < BB ? "R4 short" : "R6 full"), 1, n);
      drain("R2 byte order", n, s);
      do_ack();
      chk("R7 tx_done", int'(tx_done), 1);
      chk("R7 irq", int'(irq), 1);
      chk("R7 released", int'(data_present), 0);
      clr_irq();
      chk("R8 w1c", int'(tx_done), 0);
    end

    // R12 read stays zero while writing
    @(negedge clk); cpu_wr_en = 1'b1; cpu_wr_data = 8'hA5;
    chk("R12 during write", int'(cpu_rd_data), 0);
    @(negedge clk); cpu_wr_en = 1'b0;
    close_bank();                     // 1-byte packet A5 committed
    repeat (2) @(negedge clk);

    // R6 NAK while disabled, then data once enabled
    cpu_tx_enable = 1'b0;
    token("R6 disabled", 0, 0);
    cpu_tx_enable = 1'b1;

    // R9 and R3: close a second bank while the SIE side is busy, then write again
    fill(4, 8'h30, 1'b1);
    chk("R9 pending held", int'(data_end_pending), 1);
    wr_byte(8'h99);                   // must be ignored
    token("R6 enabled", 1, 1);
    drain("R2 single", 1, 8'hA5);
    do_ack();
    repeat (2) @(negedge clk);
    chk("R9 self clear", int'(data_end_pending), 0);
    token("R3 closed len", 1, 4);

    // R11 rewind after no-acknowledge
    drain("R11 first pass", 2, 8'h30);
    @(negedge clk); sie_noack = 1'b1;
    @(negedge clk); sie_noack = 1'b0;
    token("R11 resend", 1, 4);
    drain("R11 resent bytes", 4, 8'h30);
    // R8 ack together with clear keeps the flag set
    @(negedge clk); sie_ack = 1'b1; cpu_irq_clr = 1'b1;
    @(negedge clk); sie_ack = 1'b0; cpu_irq_clr = 1'b0;
    chk("R8 set wins", int'(tx_done), 1);
    clr_irq();

    // R3 full bank ignores extra writes
    fill(2, 8'h70, 1'b1);             // packet on SIE side
    fill(BB, 8'h00, 1'b0);            // full bank waits
    wr_byte(8'hEE);
    chk("R1 waits for SIE", int'(data_present), 1);
    token("R3 first pkt", 1, 2);
    drain("R3 first bytes", 2, 8'h70);
    do_ack();
    repeat (2) @(negedge clk);
    token("R3 full len", 1, BB);
    drain("R3 no wrap", BB, 8'h00);
    do_ack();
    clr_irq();

    // R10 clear leaves the SIE bank intact
    fill(3, 8'h40, 1'b1);
    fill(5, 8'h90, 1'b0);
    @(negedge clk); cpu_clear = 1'b1;
    @(negedge clk); cpu_clear = 1'b0;
    fill(2, 8'hB0, 1'b1);
    token("R10 sie len", 1, 3);
    drain("R10 sie bytes", 3, 8'h40);
    do_ack();
    repeat (2) @(negedge clk);
    token("R10 cleared len", 1, 2);
    drain("R10 new bytes", 2, 8'hB0);
    do_ack();

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule